// File: doc/BRIEF.md
# Promotion Buffer for a Slow-Write Instruction Cache

This block fronts a non-volatile level-1 instruction array whose writes are slow and cost much energy. Blocks refilled from level 2 after a fetch miss are not written into the array straight away. They are parked in a small fully-associative staging buffer, and each staged block keeps its own count of reuse. A block is copied into the level-1 array only once that count reaches a threshold chosen at run time. Blocks that are fetched once and never again therefore never cost an array write.

Every fetch looks up the level-1 tags and all staging tags in the same cycle. A selector returns data from whichever structure holds the block. A miss in both raises a level-2 request. The array write port is a simple request line with a busy input. The write request stays up, with steady address and data, until the array reports that it is not busy. The staging slot is released at the moment the write is taken.

Top module: `nvm_icache_promo`

## Requirements
- R1: After reset, `f_ack`, `l2_req` and `l1w_req` are low and `f_gnt` is high.
- R2: A fetch accepted while `f_gnt` is high that hits the level-1 array or the staging buffer raises `f_ack` in the next cycle, with the block's data on `f_data`. `f_src_buf` is 0 when the data comes from the array and 1 when it comes from the buffer. No level-2 request is made.
- R3: A fetch that misses both structures raises `l2_req` in the next cycle, with `l2_addr` equal to the fetch address. `l2_req` and `l2_addr` hold until `l2_vld`, and `f_gnt` stays low for that whole time.
- R4: In the cycle after `l2_vld`, `f_ack` is high with `f_data` equal to `l2_data` and `f_src_buf` equal to 1. The block is held in the staging buffer with a count of zero, and no array write is issued for it.
- R5: Each buffer hit adds one to that entry's count, which saturates at its maximum. `thr_sel` picks the threshold: 0 gives 4, 1 gives 8, and 2 or 3 gives 12. `l1w_req` rises in the cycle after the hit that brings the count to the threshold, carrying that block's address and data. It does not rise at one hit fewer.
- R6: While `l1w_busy` is high, `l1w_req`, `l1w_addr` and `l1w_data` hold steady. The write is taken at the first clock edge with `l1w_busy` low. From then on the block is served from the array (`f_src_buf` = 0).
- R7: A fetch to a block whose array write is still pending is served from the buffer, with `f_src_buf` = 1.
- R8: When the buffer is full, a refill replaces the entry with the lowest count. Among entries with equal counts it replaces the one inserted earliest. The replaced block is dropped without any array write, so its next fetch misses.
- R9: At most one buffer entry matches any address, and the entry being written to the array is never chosen for replacement.
- R10: The level-1 array is direct-mapped, indexed by the low bits of the block address. Writing a block into an occupied set displaces the block held there, so a later fetch of the displaced block misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_sel | input | 2 | Promotion threshold select (4, 8, 12, 12) |
| f_req | input | 1 | Fetch request |
| f_addr | input | ADDR_W | Fetch block address |
| f_gnt | output | 1 | Fetch can be accepted this cycle |
| f_ack | output | 1 | Fetch response valid |
| f_data | output | DATA_W | Fetch response data |
| f_src_buf | output | 1 | Response came from the staging buffer |
| l2_req | output | 1 | Level-2 refill request |
| l2_addr | output | ADDR_W | Refill block address |
| l2_vld | input | 1 | Refill data valid |
| l2_data | input | DATA_W | Refill data |
| l1w_req | output | 1 | Level-1 array write request |
| l1w_addr | output | ADDR_W | Array write block address |
| l1w_data | output | DATA_W | Array write data |
| l1w_busy | input | 1 | Array cannot take a write this cycle |

## Verification
The bench steps the hit count up to one short of each of the three thresholds and then to the threshold itself. A promotion that fires one hit early or one hit late shows up as `l1w_req` at the wrong point. It holds `l1w_busy` high across a fetch to the block being promoted. A design that freed the slot too early would then miss or report the array as the source. It fills the buffer with two entries of equal, lowest count, so a replacement rule that ignored age, or that wrote the replaced block into the array, would leave the wrong block resident. It also promotes two blocks into the same array set, so a design that did not displace the first block would keep hitting on it.

// File: rtl/promo_pkg.sv
package promo_pkg;

   typedef enum logic {
      CTL_IDLE = 1'b0,
      CTL_MISS = 1'b1
   } ctl_state_e;

   // threshold select: 0 -> 4, 1 -> 8, 2/3 -> 12
   function automatic logic [3:0] thr_decode(input logic [1:0] sel);
      logic [3:0] t;
      case (sel)
         2'd0:    t = 4'd4;
         2'd1:    t = 4'd8;
         default: t = 4'd12;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/promo_l1_array.sv
module promo_l1_array #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SETS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int IDX_W = $clog2(SETS);

   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("promo_l1_array: SETS must be a power of two of at least 2");
   end

   logic [SETS-1:0]   set_v;
   logic [ADDR_W-1:0] set_tag [SETS];
   logic [DATA_W-1:0] set_dat [SETS];

   logic [IDX_W-1:0] lk_idx, wr_idx;
   assign lk_idx = lk_addr[IDX_W-1:0];
   assign wr_idx = wr_addr[IDX_W-1:0];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            set_v[s]   <= 1'b0;
            set_tag[s] <= '0;
            set_dat[s] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(s)) begin
            set_v[s]   <= 1'b1;
            set_tag[s] <= wr_addr;
            set_dat[s] <= wr_data;
         end
      end
   end

   assign lk_hit  = set_v[lk_idx] && (set_tag[lk_idx] == lk_addr);
   assign lk_data = set_dat[lk_idx];

   // R10
   wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> set_v[$past(wr_idx)] && set_tag[$past(wr_idx)] == $past(wr_addr));

endmodule

// File: rtl/promo_buffer.sv
module promo_buffer #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int ENTRIES = 4,
   parameter int CNT_W   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           lk_addr,
   output logic                        lk_hit,
   output logic [DATA_W-1:0]           lk_data,
   input  logic                        hit_inc,
   input  logic                        ins_en,
   input  logic [ADDR_W-1:0]           ins_addr,
   input  logic [DATA_W-1:0]           ins_data,
   input  logic [CNT_W-1:0]            thr,
   input  logic                        prom_act,
   input  logic [$clog2(ENTRIES)-1:0]  prom_idx,
   input  logic                        free_en,
   output logic                        cand_any,
   output logic [$clog2(ENTRIES)-1:0]  cand_idx,
   output logic [ADDR_W-1:0]           rd_addr,
   output logic [DATA_W-1:0]           rd_data
);
   localparam int IW = $clog2(ENTRIES);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (ENTRIES < 2 || (1 << IW) != ENTRIES) begin : g_bad_entries
      $error("promo_buffer: ENTRIES must be a power of two of at least 2");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("promo_buffer: CNT_W must hold a threshold of 12");
   end

   logic [ENTRIES-1:0] ent_v;
   logic [ADDR_W-1:0]  ent_tag  [ENTRIES];
   logic [DATA_W-1:0]  ent_dat  [ENTRIES];
   logic [CNT_W-1:0]   ent_cnt  [ENTRIES];
   logic [IW-1:0]      ent_rank [ENTRIES];   // 0 = newest, higher = older

   logic [ENTRIES-1:0] hit_vec;
   logic [IW-1:0]      hit_idx;
   logic               free_any;
   logic [IW-1:0]      free_idx;
   logic               vic_any;
   logic [IW-1:0]      vic_idx;
   logic [IW-1:0]      ins_slot;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = ent_v[e] && (ent_tag[e] == lk_addr);
   end

   always_comb begin
      hit_idx = '0;
      for (int j = 0; j < ENTRIES; j++)
         if (hit_vec[j]) hit_idx = IW'(j);
   end

   assign lk_hit  = |hit_vec;
   assign lk_data = ent_dat[hit_idx];
   assign rd_addr = ent_tag[prom_idx];
   assign rd_data = ent_dat[prom_idx];

   // first free slot
   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int j = ENTRIES - 1; j >= 0; j--)
         if (!ent_v[j]) begin
            free_any = 1'b1;
            free_idx = IW'(j);
         end
   end

   // replacement choice: lowest count, then oldest; skip entry being written
   always_comb begin
      logic [CNT_W-1:0] best_cnt;
      logic [IW-1:0]    best_rank;
      vic_any   = 1'b0;
      vic_idx   = '0;
      best_cnt  = '0;
      best_rank = '0;
      for (int j = 0; j < ENTRIES; j++) begin
         if (ent_v[j] && !(prom_act && prom_idx == IW'(j))) begin
            if (!vic_any || ent_cnt[j] < best_cnt ||
                (ent_cnt[j] == best_cnt && ent_rank[j] > best_rank)) begin
               vic_any   = 1'b1;
               vic_idx   = IW'(j);
               best_cnt  = ent_cnt[j];
               best_rank = ent_rank[j];
            end
         end
      end
   end

   assign ins_slot = free_any ? free_idx : vic_idx;

   // promotion candidate: lowest index at or above threshold
   always_comb begin
      cand_any = 1'b0;
      cand_idx = '0;
      for (int j = ENTRIES - 1; j >= 0; j--)
         if (ent_v[j] && ent_cnt[j] >= thr) begin
            cand_any = 1'b1;
            cand_idx = IW'(j);
         end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic is_ins, is_free, is_hit;
      assign is_ins  = ins_en && ins_slot == IW'(e);
      assign is_free = free_en && prom_idx == IW'(e);
      assign is_hit  = hit_inc && hit_vec[e];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_v[e]    <= 1'b0;
            ent_tag[e]  <= '0;
            ent_dat[e]  <= '0;
            ent_cnt[e]  <= '0;
            ent_rank[e] <= IW'(e);
         end else begin
            if (is_ins) begin
               ent_v[e]   <= 1'b1;
               ent_tag[e] <= ins_addr;
               ent_dat[e] <= ins_data;
               ent_cnt[e] <= '0;
            end else if (is_free) begin
               ent_v[e]   <= 1'b0;
               ent_cnt[e] <= '0;
            end else if (is_hit && ent_cnt[e] != CNT_MAX) begin
               ent_cnt[e] <= ent_cnt[e] + 1'b1;
            end
            if (ins_en) begin
               if (is_ins)
                  ent_rank[e] <= '0;
               else if (ent_rank[e] < ent_rank[ins_slot])
                  ent_rank[e] <= ent_rank[e] + 1'b1;
            end
         end
      end
   end

   // R9
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9
   no_evict_prom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !free_any && prom_act) |-> ins_slot != prom_idx);

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_inc && lk_hit && !ins_en && !free_en && ent_cnt[hit_idx] != CNT_MAX)
      |=> ent_cnt[$past(hit_idx)] == $past(ent_cnt[hit_idx]) + 1'b1);

endmodule

// File: rtl/nvm_icache_promo.sv
module nvm_icache_promo #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int L1_SETS = 8,
   parameter int ENTRIES = 4,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        thr_sel,
   input  logic              f_req,
   input  logic [ADDR_W-1:0] f_addr,
   output logic              f_gnt,
   output logic              f_ack,
   output logic [DATA_W-1:0] f_data,
   output logic              f_src_buf,
   output logic              l2_req,
   output logic [ADDR_W-1:0] l2_addr,
   input  logic              l2_vld,
   input  logic [DATA_W-1:0] l2_data,
   output logic              l1w_req,
   output logic [ADDR_W-1:0] l1w_addr,
   output logic [DATA_W-1:0] l1w_data,
   input  logic              l1w_busy
);
   import promo_pkg::*;

   localparam int IW = $clog2(ENTRIES);

   if (ADDR_W <= $clog2(L1_SETS)) begin : g_bad_addr
      $error("nvm_icache_promo: ADDR_W must exceed the set index width");
   end

   ctl_state_e        st_q;
   logic [ADDR_W-1:0] miss_addr_q;
   logic              prom_act_q;
   logic [IW-1:0]     prom_idx_q;

   logic              l1_hit, buf_hit;
   logic [DATA_W-1:0] l1_data, buf_data;
   logic              cand_any;
   logic [IW-1:0]     cand_idx;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              look, hit_inc, ins_en, commit;
   logic [CNT_W-1:0]  thr;

   assign thr     = CNT_W'(thr_decode(thr_sel));
   assign look    = (st_q == CTL_IDLE) && f_req;
   assign hit_inc = look && !l1_hit && buf_hit;
   assign ins_en  = (st_q == CTL_MISS) && l2_vld;
   assign commit  = prom_act_q && !l1w_busy;

   promo_l1_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(L1_SETS)
   ) i_l1 (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(f_addr), .lk_hit(l1_hit), .lk_data(l1_data),
      .wr_en(commit), .wr_addr(rd_addr), .wr_data(rd_data)
   );

   promo_buffer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
   ) i_buf (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(f_addr), .lk_hit(buf_hit), .lk_data(buf_data),
      .hit_inc(hit_inc),
      .ins_en(ins_en), .ins_addr(miss_addr_q), .ins_data(l2_data),
      .thr(thr),
      .prom_act(prom_act_q), .prom_idx(prom_idx_q), .free_en(commit),
      .cand_any(cand_any), .cand_idx(cand_idx),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // fetch / refill control
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= CTL_IDLE;
         miss_addr_q <= '0;
         f_ack       <= 1'b0;
         f_data      <= '0;
         f_src_buf   <= 1'b0;
      end else begin
         f_ack <= 1'b0;
         case (st_q)
            CTL_IDLE: begin
               if (f_req) begin
                  if (l1_hit) begin
                     f_ack     <= 1'b1;
                     f_data    <= l1_data;
                     f_src_buf <= 1'b0;
                  end else if (buf_hit) begin
                     f_ack     <= 1'b1;
                     f_data    <= buf_data;
                     f_src_buf <= 1'b1;
                  end else begin
                     miss_addr_q <= f_addr;
                     st_q        <= CTL_MISS;
                  end
               end
            end
            CTL_MISS: begin
               if (l2_vld) begin
                  f_ack     <= 1'b1;
                  f_data    <= l2_data;
                  f_src_buf <= 1'b1;
                  st_q      <= CTL_IDLE;
               end
            end
            default: st_q <= CTL_IDLE;
         endcase
      end
   end

   // promotion engine
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prom_act_q <= 1'b0;
         prom_idx_q <= '0;
      end else if (commit) begin
         prom_act_q <= 1'b0;
      end else if (!prom_act_q && cand_any) begin
         prom_act_q <= 1'b1;
         prom_idx_q <= cand_idx;
      end
   end

   assign f_gnt    = (st_q == CTL_IDLE);
   assign l2_req   = (st_q == CTL_MISS);
   assign l2_addr  = miss_addr_q;
   assign l1w_req  = prom_act_q;
   assign l1w_addr = rd_addr;
   assign l1w_data = rd_data;

   // R3
   refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_req && !l2_vld) |=> l2_req && $stable(l2_addr));

   // R6
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l1w_req && l1w_busy) |=> l1w_req && $stable(l1w_addr) && $stable(l1w_data));

   // R4
   ack_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_req && l2_vld) |=> f_ack && f_src_buf && !l2_req);

   // R3
   gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_gnt && l2_req));

endmodule

// File: tb/test_nvm_icache_promo.sv
module test_nvm_icache_promo;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    thr_sel = 2'd0;
   logic          f_req = 1'b0;
   logic [AW-1:0] f_addr = '0;
   logic          f_gnt, f_ack, f_src_buf;
   logic [DW-1:0] f_data;
   logic          l2_req;
   logic [AW-1:0] l2_addr;
   logic          l2_vld = 1'b0;
   logic [DW-1:0] l2_data = '0;
   logic          l1w_req;
   logic [AW-1:0] l1w_addr;
   logic [DW-1:0] l1w_data;
   logic          l1w_busy = 1'b0;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;   // 125 MHz

   nvm_icache_promo #(
      .ADDR_W(AW), .DATA_W(DW), .L1_SETS(4), .ENTRIES(4), .CNT_W(4)
   ) i_nvm_icache_promo (
      .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel),
      .f_req(f_req), .f_addr(f_addr), .f_gnt(f_gnt), .f_ack(f_ack),
      .f_data(f_data), .f_src_buf(f_src_buf),
      .l2_req(l2_req), .l2_addr(l2_addr), .l2_vld(l2_vld), .l2_data(l2_data),
      .l1w_req(l1w_req), .l1w_addr(l1w_addr), .l1w_data(l1w_data),
      .l1w_busy(l1w_busy)
   );

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {a, ~a, a ^ 8'h3C, a + 8'd7};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // one fetch; hit expected with given source, or a miss serviced from level 2
   task automatic fetch(input logic [AW-1:0] a, input bit exp_hit,
                        input bit exp_buf, input string rq);
      @(negedge clk);
      chk(f_gnt == 1'b1, rq, "gnt before fetch", f_gnt, 1);
      f_req  = 1'b1;
      f_addr = a;
      @(negedge clk);
      f_req = 1'b0;
      if (exp_hit) begin
         chk(f_ack && !l2_req, rq, "hit ack", {f_ack, l2_req}, 2'b10);
         chk(f_data == pat(a), rq, "hit data", f_data, pat(a));
         chk(f_src_buf == exp_buf, rq, "hit source", f_src_buf, exp_buf);
      end else begin
         chk(l2_req && l2_addr == a && !f_ack && !f_gnt, rq, "miss request",
             {l2_req, f_ack, f_gnt, l2_addr}, {3'b100, a});
         @(negedge clk);
         @(negedge clk);
         chk(l2_req && l2_addr == a && !f_gnt, rq, "request held",
             {l2_req, f_gnt, l2_addr}, {2'b10, a});
         l2_vld  = 1'b1;
         l2_data = pat(a);
         @(negedge clk);
         l2_vld = 1'b0;
         chk(f_ack && f_src_buf && !l2_req, "R4", "refill ack",
             {f_ack, f_src_buf, l2_req}, 3'b110);
         chk(f_data == pat(a), "R4", "refill data", f_data, pat(a));
      end
   endtask

   task automatic idle_no_write(input int n, input string rq);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(!l1w_req, rq, "no early write", l1w_req, 0);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!f_ack && !l2_req && !l1w_req && f_gnt, "R1", "reset outputs",
          {f_ack, l2_req, l1w_req, f_gnt}, 4'b0001);

      // R3 R4 R5 R6 R7 threshold 4 with the array held busy
      thr_sel  = 2'd0;
      l1w_busy = 1'b1;
      fetch(8'h10, 0, 1, "R3");
      chk(!l1w_req, "R4", "no write on refill", l1w_req, 0);
      for (int k = 0; k < 3; k++) fetch(8'h10, 1, 1, "R2");
      idle_no_write(2, "R5");
      fetch(8'h10, 1, 1, "R5");
      @(negedge clk);
      chk(l1w_req && l1w_addr == 8'h10, "R5", "write at 4", {l1w_req, l1w_addr}, {1'b1, 8'h10});
      chk(l1w_data == pat(8'h10), "R5", "write data", l1w_data, pat(8'h10));
      fetch(8'h10, 1, 1, "R7");
      chk(l1w_req && l1w_addr == 8'h10, "R6", "held while busy", {l1w_req, l1w_addr}, {1'b1, 8'h10});
      l1w_busy = 1'b0;
      @(negedge clk);
      chk(!l1w_req, "R6", "write taken", l1w_req, 0);
      fetch(8'h10, 1, 0, "R6");

      // R5 threshold 8
      thr_sel = 2'd1;
      fetch(8'h21, 0, 1, "R3");
      for (int k = 0; k < 7; k++) fetch(8'h21, 1, 1, "R2");
      idle_no_write(2, "R5");
      fetch(8'h21, 1, 1, "R5");
      @(negedge clk);
      chk(l1w_req && l1w_addr == 8'h21, "R5", "write at 8", {l1w_req, l1w_addr}, {1'b1, 8'h21});
      @(negedge clk);
      fetch(8'h21, 1, 0, "R6");

      // R5 threshold 12
      thr_sel = 2'd2;
      fetch(8'h32, 0, 1, "R3");
      for (int k = 0; k < 11; k++) fetch(8'h32, 1, 1, "R2");
      idle_no_write(2, "R5");
      fetch(8'h32, 1, 1, "R5");
      @(negedge clk);
      chk(l1w_req && l1w_addr == 8'h32, "R5", "write at 12", {l1w_req, l1w_addr}, {1'b1, 8'h32});
      @(negedge clk);
      fetch(8'h32, 1, 0, "R6");

      // R8 replacement: counts 43:2 44:1 45:1 46:3, 44 is older than 45
      fetch(8'h43, 0, 1, "R8");
      fetch(8'h44, 0, 1, "R8");
      fetch(8'h45, 0, 1, "R8");
      fetch(8'h46, 0, 1, "R8");
      fetch(8'h43, 1, 1, "R8");
      fetch(8'h43, 1, 1, "R8");
      fetch(8'h44, 1, 1, "R8");
      fetch(8'h45, 1, 1, "R8");
      for (int k = 0; k < 3; k++) fetch(8'h46, 1, 1, "R8");
      fetch(8'h47, 0, 1, "R8");
      chk(!l1w_req, "R8", "no write on replace", l1w_req, 0);
      fetch(8'h45, 1, 1, "R8");
      fetch(8'h43, 1, 1, "R8");
      fetch(8'h46, 1, 1, "R8");
      fetch(8'h44, 0, 1, "R8");

      // R10 second block into set 0 displaces 0x10
      thr_sel = 2'd3;
      fetch(8'h10, 1, 0, "R10");
      thr_sel = 2'd0;
      fetch(8'h14, 0, 1, "R10");
      for (int k = 0; k < 4; k++) fetch(8'h14, 1, 1, "R10");
      @(negedge clk);
      @(negedge clk);
      chk(!l1w_req, "R10", "promotion done", l1w_req, 0);
      fetch(8'h14, 1, 0, "R10");
      fetch(8'h10, 0, 1, "R10");

      finish_run();
   end
endmodule